// File: doc/BRIEF.md
# Programmable Serial CRC Engine with Word Queue

The block computes a CRC over a stream of short data words. Words of 1 to 16 bits are written into a small input queue. A serial shifter takes the head word one bit per clock, most significant bit first, and feeds it into a linear feedback shift register. The register's length and its feedback tap mask are set by configuration inputs, so one block can serve several polynomials. The x^16+x^12+x^5+1 polynomial is one example.

Software loads the seed and queues words. It then raises the run control and polls the queued-word count, or waits for the interrupt pulse that marks the queue draining to empty. The CRC result is readable at all times and is final once the empty flag is set. A suspend input holds every piece of state where it is.

The word length is changed only while the queue is empty. The queue holds 8 words for long words and 16 words for short ones.

Top module: `crc_fifo_engine`

## Requirements
- R1: A shift step happens only when `go_i` is 1, the count is non-zero, `suspend_i` is 0, `seed_wr_i` is 0, and no full-queue write is taking place. While `go_i` is 0, the count and the CRC hold.
- R2: The word width is `len_i`+1 bits, and bit `len_i` is shifted first. Bits of `wr_data_i` above bit `len_i` have no effect on the CRC.
- R3: The queue depth is 8 when `len_i` > 7 and 16 otherwise. `full_o` is 1 exactly when the count equals the depth. `empty_o` is 1 exactly when the count is 0.
- R4: The count rises by one for each accepted write. It falls by one in the cycle that the last bit (bit 0) of the head word is shifted. N queued words drain in (`len_i`+1)*N shift cycles. A write and a word completion in the same cycle leave the count unchanged.
- R5: A write while `full_o` is 1 discards the whole queue: the count becomes 0, the partly shifted word is dropped, and `irq_o` stays 0.
- R6: `irq_o` is a one-cycle pulse. It appears in the same cycle that the count has just gone from 1 to 0 through a word completion with no write in that cycle, and at no other time.
- R7: In each shift step, fb = data bit XOR crc[`len_i`]. The next CRC is (crc << 1) XOR (fb ? `taps_i` : 0), masked to `len_i`+1 bits. Example: `len_i`=15, taps 0x1021, seed 0, one word 0x0001 gives 0x1021.
- R8: `seed_wr_i` loads the CRC with `seed_i` masked to `len_i`+1 bits at the next edge. In that cycle no bit is shifted.
- R9: While `suspend_i` is 1, the queue, the count, the bit position and the CRC hold. Writes and seed loads are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| suspend_i | input | 1 | Freeze all state |
| len_i | input | 4 | Word width minus one, also CRC length minus one |
| taps_i | input | 16 | Feedback tap mask, bit i set means XOR into stage i |
| go_i | input | 1 | Run control for the shifter |
| wr_en_i | input | 1 | Queue a data word |
| wr_data_i | input | 16 | Data word, the low `len_i`+1 bits are used |
| seed_wr_i | input | 1 | Load the seed into the CRC |
| seed_i | input | 16 | Seed value |
| crc_o | output | 16 | Current CRC register value |
| count_o | output | 5 | Number of queued words |
| full_o | output | 1 | Queue is full |
| empty_o | output | 1 | Queue is empty |
| irq_o | output | 1 | Drain-complete pulse |

## Verification
Several rules are checked as properties on every cycle:
- the CRC holds while the shifter is idle;
- all state holds under suspend;
- the full and empty flags are never both set;
- the interrupt appears only on a 1-to-0 count change;
- an overflowing write leaves the queue empty;
- a seed load lands on the next edge.

Other behaviour needs the bench's reference model and directed scenarios:
- the exact CRC values for each length and tap mask;
- the bit order within a word, and that the upper data bits are ignored;
- the drain time of (length+1) cycles per word;
- the two queue depths;
- the absence of an interrupt when a write coincides with the last word completing.

// File: rtl/crc_fifo_pkg.sv
package crc_fifo_pkg;
  localparam int unsigned CRC_W        = 16;
  localparam int unsigned LEN_W        = $clog2(CRC_W);
  localparam int unsigned DEPTH_LONG   = 8;
  localparam int unsigned DEPTH_SHORT  = 16;
  localparam int unsigned LONG_THRESH  = 7;
  localparam int unsigned CNT_W        = $clog2(DEPTH_SHORT + 1);

  function automatic logic [CRC_W-1:0] len_mask(input logic [LEN_W-1:0] len);
    logic [CRC_W-1:0] m;
    for (int i = 0; i < CRC_W; i++) m[i] = (i <= int'(len));
    return m;
  endfunction
endpackage

// File: rtl/crc_word_fifo.sv
module crc_word_fifo
  import crc_fifo_pkg::*;
#(
  parameter int unsigned W       = CRC_W,
  parameter int unsigned N_SHORT = DEPTH_SHORT,
  parameter int unsigned N_LONG  = DEPTH_LONG,
  parameter int unsigned THRESH  = LONG_THRESH,
  parameter int unsigned LW      = LEN_W,
  parameter int unsigned CW      = CNT_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [LW-1:0] len_i,
  input  logic          push_i,
  input  logic [W-1:0]  data_i,
  input  logic          pop_i,
  output logic [W-1:0]  head_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          wrap_o
);
  localparam int unsigned PTR_W = $clog2(N_SHORT);

  logic [W-1:0]     mem_q [N_SHORT];
  logic [PTR_W-1:0] rd_q, wr_q;
  logic [CW-1:0]    count_q, depth, last_idx;
  logic             push_ok, pop_ok;

  assign depth    = (int'(len_i) > int'(THRESH)) ? CW'(N_LONG) : CW'(N_SHORT);
  assign last_idx = depth - 1'b1;
  assign full_o   = (count_q == depth);
  assign empty_o  = (count_q == '0);
  assign wrap_o   = en_i & push_i & full_o;
  assign push_ok  = en_i & push_i & ~full_o;
  assign pop_ok   = en_i & pop_i & ~wrap_o & ~empty_o;
  assign head_o   = mem_q[rd_q];
  assign count_o  = count_q;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p,
                                            input logic [CW-1:0] lim);
    return (CW'(p) == lim) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q    <= '0;
      wr_q    <= '0;
      count_q <= '0;
    end else if (wrap_o) begin
      rd_q    <= '0;
      wr_q    <= '0;
      count_q <= '0;
    end else begin
      if (push_ok) wr_q <= bump(wr_q, last_idx);
      if (pop_ok)  rd_q <= bump(rd_q, last_idx);
      case ({push_ok, pop_ok})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  assert_wrap_empty_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> (count_o == '0) && empty_o);

  assert_push_nonempty_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_ok && !pop_ok) |=> !empty_o);
endmodule

// File: rtl/crc_lfsr_core.sv
module crc_lfsr_core
  import crc_fifo_pkg::*;
#(
  parameter int unsigned W  = CRC_W,
  parameter int unsigned LW = LEN_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_i,
  input  logic          bit_i,
  input  logic          seed_wr_i,
  input  logic [W-1:0]  seed_i,
  input  logic [LW-1:0] len_i,
  input  logic [W-1:0]  taps_i,
  output logic [W-1:0]  crc_o
);
  logic [W-1:0] crc_q, nxt, mask;
  logic         fb;

  assign mask = len_mask(len_i);
  assign fb   = bit_i ^ crc_q[len_i];

  for (genvar g = 0; g < W; g++) begin : g_stage
    if (g == 0) begin : g_lsb
      assign nxt[g] = taps_i[g] & fb;
    end else begin : g_up
      assign nxt[g] = crc_q[g-1] ^ (taps_i[g] & fb);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        crc_q <= '0;
    else if (seed_wr_i) crc_q <= seed_i & mask;
    else if (step_i)    crc_q <= nxt & mask;
  end

  assign crc_o = crc_q;

  assert_seed_load_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seed_wr_i |=> crc_q == ($past(seed_i) & len_mask($past(len_i))));
endmodule

// File: rtl/crc_fifo_engine.sv
module crc_fifo_engine
  import crc_fifo_pkg::*;
#(
  parameter int unsigned W  = CRC_W,
  parameter int unsigned LW = LEN_W,
  parameter int unsigned CW = CNT_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          suspend_i,
  input  logic [LW-1:0] len_i,
  input  logic [W-1:0]  taps_i,
  input  logic          go_i,
  input  logic          wr_en_i,
  input  logic [W-1:0]  wr_data_i,
  input  logic          seed_wr_i,
  input  logic [W-1:0]  seed_i,
  output logic [W-1:0]  crc_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          irq_o
);
  logic [W-1:0]  head;
  logic [LW-1:0] bit_cnt_q;
  logic          wrap, step, last_bit, pop, irq_q, run;

  assign run      = ~suspend_i;
  assign step     = go_i & ~empty_o & run & ~wrap & ~seed_wr_i;
  assign last_bit = (bit_cnt_q == len_i);
  assign pop      = step & last_bit;

  crc_word_fifo #(.W(W), .LW(LW), .CW(CW)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (run),
    .len_i   (len_i),
    .push_i  (wr_en_i),
    .data_i  (wr_data_i),
    .pop_i   (pop),
    .head_o  (head),
    .count_o (count_o),
    .full_o  (full_o),
    .empty_o (empty_o),
    .wrap_o  (wrap)
  );

  crc_lfsr_core #(.W(W), .LW(LW)) u_lfsr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .step_i    (step),
    .bit_i     (head[len_i - bit_cnt_q]),
    .seed_wr_i (seed_wr_i & run),
    .seed_i    (seed_i),
    .len_i     (len_i),
    .taps_i    (taps_i),
    .crc_o     (crc_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt_q <= '0;
      irq_q     <= 1'b0;
    end else begin
      irq_q <= pop & ~wr_en_i & (count_o == CW'(1));
      if (run) begin
        if (wrap || pop) bit_cnt_q <= '0;
        else if (step)   bit_cnt_q <= bit_cnt_q + 1'b1;
      end
    end
  end

  assign irq_o = irq_q;

  assert_idle_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!go_i && !seed_wr_i) |=> $stable(crc_o));

  assert_suspend_freeze_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    suspend_i |=> $stable(crc_o) && $stable(count_o));

  assert_flags_exclusive_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o));

  assert_irq_source_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (count_o == '0) && ($past(count_o) == CW'(1)));
endmodule

// File: tb/crc_fifo_engine_test.sv
module crc_fifo_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        suspend = 1'b0, go = 1'b0, wr_en = 1'b0, seed_wr = 1'b0;
  logic [3:0]  len = 4'd15;
  logic [15:0] taps = 16'h1021, wr_data = '0, seed = '0;
  logic [15:0] crc;
  logic [4:0]  count;
  logic        full, empty, irq;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  crc_fifo_engine uut (
    .clk_i(clk), .rst_ni(rst_n), .suspend_i(suspend), .len_i(len), .taps_i(taps),
    .go_i(go), .wr_en_i(wr_en), .wr_data_i(wr_data), .seed_wr_i(seed_wr), .seed_i(seed),
    .crc_o(crc), .count_o(count), .full_o(full), .empty_o(empty), .irq_o(irq)
  );

  // reference model
  int          m_q[$];
  logic [15:0] m_crc;
  int          m_bc;
  bit          m_irq;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q.delete(); m_crc = '0; m_bc = 0; m_irq = 0;
    end else begin
      m_irq = 0;
      if (!suspend) begin
        int   depth;
        bit   wfull, stp;
        logic [15:0] msk;
        depth = (len > 7) ? 8 : 16;
        msk   = 16'((32'd1 << (int'(len) + 1)) - 1);
        wfull = wr_en && (m_q.size() == depth);
        stp   = go && (m_q.size() > 0) && !wfull && !seed_wr;
        if (seed_wr) m_crc = seed & msk;
        if (stp) begin
          bit b, fb;
          b  = (m_q[0] >> (int'(len) - m_bc)) & 1;
          fb = b ^ m_crc[len];
          m_crc = ((m_crc << 1) ^ (fb ? taps : 16'h0)) & msk;
          if (m_bc == int'(len)) begin
            void'(m_q.pop_front());
            m_bc = 0;
            if (m_q.size() == 0 && !wr_en) m_irq = 1;
          end else m_bc++;
        end
        if (wr_en) begin
          if (wfull) begin m_q.delete(); m_bc = 0; end
          else m_q.push_back(int'(wr_data));
        end
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      int depth;
      depth = (len > 7) ? 8 : 16;
      chk("R7 crc", int'(crc), int'(m_crc));
      chk("R4 count", int'(count), m_q.size());
      chk("R3 full", int'(full), int'(m_q.size() == depth));
      chk("R3 empty", int'(empty), int'(m_q.size() == 0));
      chk("R6 irq", int'(irq), int'(m_irq));
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put(input logic [15:0] d);
    wr_en = 1; wr_data = d; tick(1); wr_en = 0;
  endtask

  task automatic load_seed(input logic [15:0] s);
    seed_wr = 1; seed = s; tick(1); seed_wr = 0;
  endtask

  task automatic drain();
    go = 1; wr_en = 0; suspend = 0; seed_wr = 0;
    for (int i = 0; i < 400 && !empty; i++) tick(1);
    go = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    logic [15:0] snap_crc, c1;
    logic [4:0]  snap_cnt;
    tick(2);
    rst_n = 1;
    tick(1);
    chk("R3 reset empty", int'(empty), 1);
    chk("R4 reset count", int'(count), 0);
    chk("R6 reset irq", int'(irq), 0);
    chk("R7 reset crc", int'(crc), 0);

    // R7 / R4 / R6: single 16-bit word 0x0001
    len = 15; taps = 16'h1021;
    load_seed(16'h0000);
    wr_en = 1; wr_data = 16'h0001; go = 1; tick(1); wr_en = 0;
    tick(15);
    chk("R4 count before last bit", int'(count), 1);
    tick(1);
    chk("R4 drained after 16 cycles", int'(count), 0);
    chk("R6 irq pulse", int'(irq), 1);
    chk("R7 ccitt value", int'(crc), 16'h1021);
    tick(1);
    chk("R6 irq one cycle", int'(irq), 0);
    go = 0;

    // R1: no shifting with go low
    put(16'h1234); put(16'hABCD); put(16'h0F0F);
    snap_crc = crc;
    tick(10);
    chk("R1 count held", int'(count), 3);
    chk("R1 crc held", int'(crc), int'(snap_crc));
    go = 1; tick(47);
    chk("R4 count after 47", int'(count), 1);
    tick(1);
    chk("R4 three words in 48", int'(count), 0);
    go = 0;

    // R2: upper bits ignored at len 7
    len = 7;
    load_seed(16'h0000); put(16'hFFA5); drain(); c1 = crc;
    load_seed(16'h0000); put(16'h00A5); drain();
    chk("R2 upper bits ignored", int'(crc), int'(c1));

    // R3 / R5: short words, depth 16, then overflow
    len = 3;
    for (int i = 0; i < 16; i++) put(16'(i));
    chk("R3 full at 16", int'(full), 1);
    put(16'h5);
    chk("R5 wrap count", int'(count), 0);
    chk("R5 wrap empty", int'(empty), 1);
    chk("R5 no irq", int'(irq), 0);

    // R3: long words, depth 8
    len = 9;
    for (int i = 0; i < 7; i++) put(16'(i * 77));
    chk("R3 not full at 7", int'(full), 0);
    put(16'h3FF);
    chk("R3 full at 8", int'(full), 1);
    drain();

    // R9: suspend
    len = 15;
    put(16'hDEAD); put(16'hBEEF);
    go = 1; tick(5);
    suspend = 1; tick(1);
    snap_crc = crc; snap_cnt = count;
    wr_en = 1; wr_data = 16'h1111; seed_wr = 1; seed = 16'h7777;
    tick(10);
    wr_en = 0; seed_wr = 0;
    chk("R9 crc frozen", int'(crc), int'(snap_crc));
    chk("R9 count frozen", int'(count), int'(snap_cnt));
    suspend = 0;
    drain();

    // R8: seed masked to length
    len = 7;
    load_seed(16'hBEEF);
    chk("R8 seed masked", int'(crc), 16'h00EF);

    // R10-style mixed traffic against model
    for (int ph = 0; ph < 12; ph++) begin
      drain();
      len  = 4'($urandom_range(0, 15));
      taps = 16'($urandom);
      for (int c = 0; c < 300; c++) begin
        wr_en   = ($urandom % 3) == 0;
        wr_data = 16'($urandom);
        go      = ($urandom % 8) != 0;
        suspend = ($urandom % 16) == 0;
        seed_wr = ($urandom % 64) == 0;
        seed    = 16'($urandom);
        tick(1);
      end
    end
    drain();
    tick(2);
    finish_run();
  end
endmodule